// File: doc/BRIEF.md
# Two-Way Cache Debug Readout Unit

This block holds the tag, valid, LRU and data storage of a two-way set-associative instruction cache and provides a privileged debug path for reading it. A debug request supplies a base operand, a flag saying the base field is zero, an index operand, a privilege flag and two control bits. The block adds the operands to form an effective address. It takes the set and the word from that address, picks either a data word or a packed tag-status word from way A or way B, and latches the result into a debug data register. That register is then read out on its own port.

A request made without privilege does not read. It leaves the debug register alone and raises a one-cycle fault pulse. A request made while the cache-present input is low completes with no effect. A simple preload port writes data words, tags, valid flags and the per-set LRU bit so that the arrays can be filled for testing. Line fills, hit detection and replacement updates are not part of this block. The set count is a parameter. Nine set bits give the full 512-set organisation, and the default build uses six set bits to keep the storage small.

Top module: `icache_dbg_read`

## Requirements
- R1: The effective address is `req_index + req_base`, modulo 2^32. When `req_ra_zero` is 1, the base term is taken as zero whatever `req_base` holds.
- R2: The set is taken from effective-address bits [5 +: SET_W] (LSB-first numbering). With SET_W = 9 this is bits 18..26 in MSB-first numbering. Address bits above the set field have no effect on the result.
- R3: The word within the line is effective-address bits [4:2] (MSB-first 27..29). Bits [1:0] have no effect.
- R4: When `req_cis` = 0, the latched value is the 32-bit data word at the addressed set and word. It comes from way A when `req_cws` = 0 and from way B when `req_cws` = 1.
- R5: When `req_cis` = 1, the latched value is a tag word for the way chosen by `req_cws`. The tag word holds the 22-bit tag in bits [31:10], the valid flag in bit 4 and the set's LRU bit in bit 0, with every other bit zero. The LRU bit is shared by both ways of a set: 0 means way A is least recently used and 1 means way B is.
- R6: `dbg_data` takes the selected value at the clock edge that samples a request with `req_valid`, `req_priv` and `cache_present` all 1. In every other cycle it holds its value.
- R7: A request with `req_valid` = 1 and `req_priv` = 0 leaves `dbg_data` unchanged. It drives `priv_fault` high for exactly the one cycle after that edge. This applies whatever the value of `cache_present`.
- R8: A privileged request made while `cache_present` = 0 leaves `dbg_data` unchanged and does not raise `priv_fault`.
- R9: While reset is active, `dbg_data` reads 0 and `priv_fault` reads 0.
- R10: A preload write to the data, tag/valid or LRU storage is returned by any later debug read of that location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cache_present | input | 1 | High when the cache arrays are present |
| req_valid | input | 1 | Debug read request |
| req_base | input | 32 | Base operand |
| req_ra_zero | input | 1 | Base field is zero, so the base term is taken as 0 |
| req_index | input | 32 | Index operand |
| req_priv | input | 1 | Request is privileged |
| req_cis | input | 1 | 0 = read a data word, 1 = read a tag word |
| req_cws | input | 1 | 0 = way A, 1 = way B |
| pl_data_en | input | 1 | Preload one data word |
| pl_tag_en | input | 1 | Preload the tag and valid flag of one way and set |
| pl_lru_en | input | 1 | Preload the LRU bit of one set |
| pl_way | input | 1 | Way targeted by the preload |
| pl_set | input | SET_W | Set targeted by the preload |
| pl_word | input | 3 | Word targeted by a data preload |
| pl_wdata | input | 32 | Data word, or the tag in bits [21:0] |
| pl_valid | input | 1 | Valid flag written with the tag |
| pl_lru | input | 1 | LRU bit value |
| dbg_data | output | 32 | Debug data register |
| priv_fault | output | 1 | One-cycle pulse after an unprivileged request |

## Verification
The condition hardest to reach from the ports is a single debug register value surviving a series of requests that must not touch it. This covers an unprivileged request with the cache present, an unprivileged request with the cache absent, and a privileged request with the cache absent. The bench first latches a known data word. It then issues each of these requests using addresses whose target locations hold values that differ from the latched one, so any stray update shows up at `dbg_data`. The fault pulse is sampled in the cycle after each request and again one cycle later. Every address is built in one of three forms: base forced to zero, base plus an offset, and base plus a negative index that wraps. Junk is placed in the bits above the set field and in the byte offset, so that the address adder and the field extraction are exercised on every location.

// File: rtl/icdbg_pkg.sv
package icdbg_pkg;
  localparam int WORD_W     = 32;
  localparam int TAG_W      = 22;
  localparam int WSEL_W     = 3;
  localparam int BOFF_W     = 2;
  localparam int SET_LSB    = WSEL_W + BOFF_W;
  localparam int TAG_LSB    = WORD_W - TAG_W;
  localparam int VALID_POS  = 4;
  localparam int LRU_POS    = 0;
  localparam int NUM_WAYS   = 2;

  function automatic logic [WORD_W-1:0] pack_tag_word(
    input logic [TAG_W-1:0] tag,
    input logic             valid,
    input logic             lru
  );
    logic [WORD_W-1:0] w;
    w = '0;
    w[WORD_W-1:TAG_LSB] = tag;
    w[VALID_POS]        = valid;
    w[LRU_POS]          = lru;
    return w;
  endfunction
endpackage

// File: rtl/icdbg_ea_gen.sv
module icdbg_ea_gen
  import icdbg_pkg::*;
#(
  parameter int SET_W = 6
) (
  input  logic [WORD_W-1:0] base,
  input  logic              ra_zero,
  input  logic [WORD_W-1:0] index,
  output logic [SET_W-1:0]  set_idx,
  output logic [WSEL_W-1:0] word_idx
);
  logic [WORD_W-1:0] base_eff;
  logic [WORD_W-1:0] ea;

  always_comb begin
    base_eff = ra_zero ? '0 : base;
    ea       = index + base_eff;
    set_idx  = ea[SET_LSB +: SET_W];
    word_idx = ea[BOFF_W +: WSEL_W];
  end
endmodule

// File: rtl/icdbg_way_store.sv
module icdbg_way_store
  import icdbg_pkg::*;
#(
  parameter int SET_W = 6
) (
  input  logic              clk,
  input  logic              data_we,
  input  logic              tag_we,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_valid,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_data,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              rd_valid
);
  localparam int SETS    = 1 << SET_W;
  localparam int DEPTH   = SETS << WSEL_W;
  localparam int DADDR_W = SET_W + WSEL_W;

  logic [WORD_W-1:0] data_mem  [DEPTH];
  logic [TAG_W-1:0]  tag_mem   [SETS];
  logic              valid_mem [SETS];

  logic [DADDR_W-1:0] wr_addr;
  logic [DADDR_W-1:0] rd_addr;

  always_comb begin
    wr_addr = {wr_set, wr_word};
    rd_addr = {rd_set, rd_word};
  end

  always_ff @(posedge clk) begin
    if (data_we) data_mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (tag_we) begin
      tag_mem[wr_set]   <= wr_data[TAG_W-1:0];
      valid_mem[wr_set] <= wr_valid;
    end
  end

  always_comb begin
    rd_data  = data_mem[rd_addr];
    rd_tag   = tag_mem[rd_set];
    rd_valid = valid_mem[rd_set];
  end
endmodule

// File: rtl/icdbg_lru_store.sv
module icdbg_lru_store #(
  parameter int SET_W = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [SET_W-1:0] wr_set,
  input  logic             wr_lru,
  input  logic [SET_W-1:0] rd_set,
  output logic             rd_lru
);
  localparam int SETS = 1 << SET_W;

  logic lru_mem [SETS];

  always_ff @(posedge clk) begin
    if (we) lru_mem[wr_set] <= wr_lru;
  end

  always_comb rd_lru = lru_mem[rd_set];
endmodule

// File: rtl/icache_dbg_read.sv
module icache_dbg_read
  import icdbg_pkg::*;
#(
  parameter int SET_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_present,
  input  logic              req_valid,
  input  logic [31:0]       req_base,
  input  logic              req_ra_zero,
  input  logic [31:0]       req_index,
  input  logic              req_priv,
  input  logic              req_cis,
  input  logic              req_cws,
  input  logic              pl_data_en,
  input  logic              pl_tag_en,
  input  logic              pl_lru_en,
  input  logic              pl_way,
  input  logic [SET_W-1:0]  pl_set,
  input  logic [2:0]        pl_word,
  input  logic [31:0]       pl_wdata,
  input  logic              pl_valid,
  input  logic              pl_lru,
  output logic [31:0]       dbg_data,
  output logic              priv_fault
);
  localparam logic [WORD_W-1:0] RSVD_MASK = 32'h0000_03EE;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // address decode
  logic [SET_W-1:0]  rd_set;
  logic [WSEL_W-1:0] rd_word;

  icdbg_ea_gen #(.SET_W(SET_W)) u_ea (
    .base     (req_base),
    .ra_zero  (req_ra_zero),
    .index    (req_index),
    .set_idx  (rd_set),
    .word_idx (rd_word)
  );

  // per-way storage
  logic [WORD_W-1:0] way_data  [NUM_WAYS];
  logic [TAG_W-1:0]  way_tag   [NUM_WAYS];
  logic              way_valid [NUM_WAYS];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic sel_way;
    always_comb sel_way = (pl_way == w[0]);

    icdbg_way_store #(.SET_W(SET_W)) u_store (
      .clk      (clk),
      .data_we  (pl_data_en & sel_way),
      .tag_we   (pl_tag_en & sel_way),
      .wr_set   (pl_set),
      .wr_word  (pl_word),
      .wr_data  (pl_wdata),
      .wr_valid (pl_valid),
      .rd_set   (rd_set),
      .rd_word  (rd_word),
      .rd_data  (way_data[w]),
      .rd_tag   (way_tag[w]),
      .rd_valid (way_valid[w])
    );
  end

  logic set_lru;

  icdbg_lru_store #(.SET_W(SET_W)) u_lru (
    .clk    (clk),
    .we     (pl_lru_en),
    .wr_set (pl_set),
    .wr_lru (pl_lru),
    .rd_set (rd_set),
    .rd_lru (set_lru)
  );

  // result selection
  logic [WORD_W-1:0] sel_word;
  logic              rd_fire;
  logic              fault_req;

  always_comb begin
    if (req_cis) sel_word = pack_tag_word(way_tag[req_cws], way_valid[req_cws], set_lru);
    else         sel_word = way_data[req_cws];
    fault_req = req_valid & ~req_priv;
    rd_fire   = req_valid & req_priv & cache_present;
  end

  // next state
  logic [WORD_W-1:0] dbg_nxt;
  logic              fault_nxt;
  logic              dbg_en;

  always_comb begin
    dbg_en    = rd_fire;
    dbg_nxt   = sel_word;
    fault_nxt = fault_req;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dbg_data <= '0;
    end else if (dbg_en) begin
      dbg_data <= dbg_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) priv_fault <= 1'b0;
    else             priv_fault <= fault_nxt;
  end

  // checks
  AST_NOPRIV_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !req_priv) |=> $stable(dbg_data)); // R7

  AST_NOPRIV_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !req_priv) |=> priv_fault); // R7

  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    priv_fault |-> $past(req_valid && !req_priv)); // R7

  AST_ABSENT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_priv && !cache_present) |=> ($stable(dbg_data) && !priv_fault)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> $stable(dbg_data)); // R6

  AST_TAG_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_fire && req_cis) |=> ((dbg_data & RSVD_MASK) == '0)); // R5

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_sync_n |-> (dbg_data == '0 && !priv_fault)); // R9
endmodule

// File: tb/tb_icache_dbg_read.sv
module tb_icache_dbg_read;
  localparam int SET_W = 6;
  localparam int SETS  = 1 << SET_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cache_present;
  logic              req_valid;
  logic [31:0]       req_base;
  logic              req_ra_zero;
  logic [31:0]       req_index;
  logic              req_priv;
  logic              req_cis;
  logic              req_cws;
  logic              pl_data_en;
  logic              pl_tag_en;
  logic              pl_lru_en;
  logic              pl_way;
  logic [SET_W-1:0]  pl_set;
  logic [2:0]        pl_word;
  logic [31:0]       pl_wdata;
  logic              pl_valid;
  logic              pl_lru;
  logic [31:0]       dbg_data;
  logic              priv_fault;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  icache_dbg_read #(.SET_W(SET_W)) dut (
    .clk(clk), .rst_n(rst_n), .cache_present(cache_present),
    .req_valid(req_valid), .req_base(req_base), .req_ra_zero(req_ra_zero),
    .req_index(req_index), .req_priv(req_priv), .req_cis(req_cis), .req_cws(req_cws),
    .pl_data_en(pl_data_en), .pl_tag_en(pl_tag_en), .pl_lru_en(pl_lru_en),
    .pl_way(pl_way), .pl_set(pl_set), .pl_word(pl_word), .pl_wdata(pl_wdata),
    .pl_valid(pl_valid), .pl_lru(pl_lru),
    .dbg_data(dbg_data), .priv_fault(priv_fault)
  );

  function automatic logic [31:0] exp_data(int way, int set, int word);
    return (way != 0 ? 32'hB000_0000 : 32'h4000_0000)
         | 32'(set << 8) | 32'(word << 4) | 32'((set * 7 + word * 3) & 15);
  endfunction

  function automatic logic [21:0] exp_tag(int way, int set);
    return 22'((set * 40961 + way * 123457 + 5) & 32'h3F_FFFF);
  endfunction

  function automatic logic exp_valid(int way, int set);
    return ((set + way) % 3) != 0;
  endfunction

  function automatic logic exp_lru(int set);
    return 1'((set & 1) ^ ((set >> 2) & 1));
  endfunction

  function automatic logic [31:0] exp_tagword(int way, int set);
    return {exp_tag(way, set), 5'b0, exp_valid(way, set), 3'b0, exp_lru(set)};
  endfunction

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one request; returns after the capture edge, sampled at negedge
  task automatic do_req(logic [31:0] base, logic ra0, logic [31:0] idx,
                        logic priv, logic cis, logic cws, logic present);
    @(negedge clk);
    req_valid = 1'b1; req_base = base; req_ra_zero = ra0; req_index = idx;
    req_priv = priv; req_cis = cis; req_cws = cws; cache_present = present;
    @(negedge clk);
    req_valid = 1'b0; cache_present = 1'b1;
  endtask

  // build operands in one of three forms that add up to ea
  task automatic make_ops(int form, logic [31:0] ea, output logic [31:0] base,
                          output logic ra0, output logic [31:0] idx);
    case (form)
      0: begin ra0 = 1'b1; base = 32'hDEAD_BEEF; idx = ea; end
      1: begin ra0 = 1'b0; idx = 32'h1234_5673; base = ea - idx; end
      default: begin ra0 = 1'b0; idx = 32'hFFFF_FFC0; base = ea + 32'h40; end
    endcase
  endtask

  function automatic logic [31:0] make_ea(int set, int word, int salt);
    return (32'(salt * 32'h9E37_79B9) & 32'hFFFF_F800) | 32'(set << 5) | 32'(word << 2) | 32'(salt & 3);
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] b, ix, held;
    logic r0;
    rst_n = 1'b0; cache_present = 1'b1; req_valid = 1'b0; req_base = '0;
    req_ra_zero = 1'b0; req_index = '0; req_priv = 1'b0; req_cis = 1'b0; req_cws = 1'b0;
    pl_data_en = 1'b0; pl_tag_en = 1'b0; pl_lru_en = 1'b0; pl_way = 1'b0;
    pl_set = '0; pl_word = '0; pl_wdata = '0; pl_valid = 1'b0; pl_lru = 1'b0;
    repeat (4) @(negedge clk);
    check32("R9 dbg_data in reset", dbg_data, 32'h0);
    check32("R9 priv_fault in reset", {31'b0, priv_fault}, 32'h0);

    // preload, R10
    for (int w = 0; w < 2; w++) begin
      for (int s = 0; s < SETS; s++) begin
        for (int k = 0; k < 8; k++) begin
          @(negedge clk);
          pl_data_en = 1'b1; pl_way = w[0]; pl_set = s[SET_W-1:0];
          pl_word = k[2:0]; pl_wdata = exp_data(w, s, k);
        end
        @(negedge clk);
        pl_data_en = 1'b0; pl_tag_en = 1'b1; pl_way = w[0]; pl_set = s[SET_W-1:0];
        pl_wdata = {10'h3FF, exp_tag(w, s)}; pl_valid = exp_valid(w, s);
        pl_lru_en = (w == 0); pl_lru = exp_lru(s);
      end
    end
    @(negedge clk);
    pl_data_en = 1'b0; pl_tag_en = 1'b0; pl_lru_en = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check32("R9 dbg_data after reset release", dbg_data, 32'h0);

    // data sweep: R1 R2 R3 R4 R6 R10
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < SETS; s++)
        for (int k = 0; k < 8; k++) begin
          make_ops((s + k + w) % 3, make_ea(s, k, s * 8 + k + w), b, r0, ix);
          do_req(b, r0, ix, 1'b1, 1'b0, w[0], 1'b1);
          check32("R1/R2/R3/R4 data read", dbg_data, exp_data(w, s, k));
        end

    // tag sweep: R5 R10
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < SETS; s++) begin
        make_ops(s % 3, make_ea(s, (s * 5) % 8, s + 17 * w), b, r0, ix);
        do_req(b, r0, ix, 1'b1, 1'b1, w[0], 1'b1);
        check32("R5 tag word", dbg_data, exp_tagword(w, s));
      end

    // hold behaviour: R6 R7 R8
    do_req(32'h0, 1'b1, make_ea(5, 3, 0), 1'b1, 1'b0, 1'b1, 1'b1);
    held = dbg_data;
    check32("R6 known latch", held, exp_data(1, 5, 3));
    check32("R6 no fault on privileged", {31'b0, priv_fault}, 32'h0);
    @(negedge clk);
    check32("R6 idle hold", dbg_data, held);

    do_req(32'h0, 1'b1, make_ea(9, 1, 2), 1'b0, 1'b0, 1'b0, 1'b1);
    check32("R7 unprivileged no update", dbg_data, held);
    check32("R7 fault pulse", {31'b0, priv_fault}, 32'h1);
    @(negedge clk);
    check32("R7 fault one cycle", {31'b0, priv_fault}, 32'h0);

    do_req(32'h0, 1'b1, make_ea(12, 6, 1), 1'b0, 1'b1, 1'b1, 1'b0);
    check32("R7 unprivileged absent no update", dbg_data, held);
    check32("R7 fault pulse while absent", {31'b0, priv_fault}, 32'h1);

    do_req(32'h0, 1'b1, make_ea(20, 2, 3), 1'b1, 1'b0, 1'b0, 1'b0);
    check32("R8 absent no update", dbg_data, held);
    check32("R8 absent no fault", {31'b0, priv_fault}, 32'h0);

    // R1 wrap of sum with ra_zero ignoring base
    do_req(32'hFFFF_FFFF, 1'b1, make_ea(33, 7, 0), 1'b1, 1'b0, 1'b0, 1'b1);
    check32("R1 base ignored when ra_zero", dbg_data, exp_data(0, 33, 7));

    // R9 asynchronous reset clears
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check32("R9 async clear", dbg_data, 32'h0);
    check32("R9 async fault clear", {31'b0, priv_fault}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule